// File: doc/BRIEF.md
# Flag-Setting Integer Execute Unit with Conditional Select

This block is the integer execute stage of a small in-order core. In one cycle it performs an add, subtract, AND, OR, XOR or bitwise-not on 64-bit operands, or on their low 32 bits in narrow mode. A four-bit flag register holds the negative, zero, carry and overflow state. The flag register changes only when the operation asks for it. Compare and test use the subtract and AND datapaths, update the flags and discard their result.

A condition evaluator reads the stored flags and decodes a 4-bit condition code. The same evaluator drives two consumers. The first is the select path, which chooses operand A, operand B or B+1 for the destination. The second is the branch-resolution output, which also covers register-zero tests and single-bit tests. Results are combinational in the issue cycle. A flag update takes effect at the next rising clock edge, so a compare issued in one cycle steers a select or branch in the following cycle.

Top module: `cxu_top`

## Requirements
- R1: `flags` resets to 0000. At a rising edge it is loaded only for ADD(0), SUB(1), AND(2), ORR(3), EOR(4) or MVN(5) with `set_flags`=1, and always for CMP(6) and TST(7). For every other opcode (CSEL 8, CSINC 9, CBZ 10, CBNZ 11, TBZ 12, TBNZ 13, BCOND 14, NOP 15), and for opcodes 0-5 without `set_flags`, it holds its value.
- R2: The flag bits are N=`flags[3]`, Z=`flags[2]`, C=`flags[1]` and V=`flags[0]`. Z is 1 when the operation's value at the selected width is zero. N is that value's top bit.
- R3: ADD gives A+B and SUB/CMP give A-B. For an add, C is the carry out. For a subtract, C is 1 when A is greater than or equal to B as unsigned values. V is signed overflow. AND, ORR, EOR, MVN and TST clear C and V. MVN gives ~B.
- R4: When `wide`=0, operations use the low 32 bits, result bits 63:32 are zero, and all flags come from the 32-bit value.
- R5: CMP and TST drive `result`=0 and `res_we`=0. ALU ops 0-5 and the select ops 8-9 drive `res_we`=1.
- R6: Conditions on the stored flags are: 0 Z; 1 !Z; 2 C; 3 !C; 4 N; 5 !N; 6 V; 7 !V; 8 C&!Z; 9 !C|Z; 10 N==V; 11 N!=V; 12 !Z&(N==V); 13 Z|(N!=V); 14 and 15 always true.
- R7: CSEL outputs A when the condition holds and B otherwise.
- R8: CSINC outputs A when the condition holds and B+1 otherwise. The increment wraps at the selected width. With A equal to B this is a conditional increment.
- R9: CBZ asserts `taken` when A is zero at the selected width. CBNZ asserts it when A is nonzero.
- R10: TBZ asserts `taken` when bit `bit_sel` of A is 0. TBNZ asserts it when that bit is 1.
- R11: BCOND asserts `taken` exactly when the condition holds. `taken` is 0 for opcodes 0-9 and 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 4 | Operation select (encodings in R1) |
| wide | input | 1 | 1: 64-bit operation, 0: 32-bit |
| set_flags | input | 1 | Request flag update for ops 0-5 |
| cond | input | 4 | Condition code (R6) |
| opa | input | 64 | Operand A / tested register |
| opb | input | 64 | Operand B |
| bit_sel | input | 6 | Bit index for test-bit branches |
| result | output | 64 | Destination value |
| res_we | output | 1 | Destination write enable |
| taken | output | 1 | Branch resolution |
| flags | output | 4 | Stored N, Z, C, V |

## Verification
The checker watches on every cycle that the flags stay unchanged after any operation that does not request an update, that compare and test never write a destination, and that narrow results have clear upper bits. It also checks that the always and equal conditions follow the stored Z bit, and that taken stays low outside branch opcodes. Carry and overflow values at both widths, all sixteen conditions under several flag states, the select and increment values including the 32-bit wrap, and the zero and bit tests can only be shown by the bench. Its scenarios compute those values from an independent model.

// File: rtl/cxu_pkg.sv
package cxu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_AND   = 4'd2,
    OP_ORR   = 4'd3,
    OP_EOR   = 4'd4,
    OP_MVN   = 4'd5,
    OP_CMP   = 4'd6,
    OP_TST   = 4'd7,
    OP_CSEL  = 4'd8,
    OP_CSINC = 4'd9,
    OP_CBZ   = 4'd10,
    OP_CBNZ  = 4'd11,
    OP_TBZ   = 4'd12,
    OP_TBNZ  = 4'd13,
    OP_BCOND = 4'd14,
    OP_NOP   = 4'd15
  } cxu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  // Signed overflow: operands share a sign that the result does not.
  function automatic logic ovf_of(input logic a_msb, input logic b_msb,
                                  input logic r_msb);
    return (a_msb == b_msb) && (r_msb != a_msb);
  endfunction

  // Carry out of bit k-1, recovered from bit k of a wider sum.
  function automatic logic carry_into(input logic sum_k, input logic a_k,
                                      input logic b_k);
    return sum_k ^ a_k ^ b_k;
  endfunction

  // Flat condition decode on stored flags.
  function automatic logic cond_holds(input logic [3:0] code, input nzcv_t f);
    logic r;
    case (code)
      4'd0:    r = f.z;
      4'd1:    r = !f.z;
      4'd2:    r = f.c;
      4'd3:    r = !f.c;
      4'd4:    r = f.n;
      4'd5:    r = !f.n;
      4'd6:    r = f.v;
      4'd7:    r = !f.v;
      4'd8:    r = f.c && !f.z;
      4'd9:    r = !f.c || f.z;
      4'd10:   r = (f.n == f.v);
      4'd11:   r = (f.n != f.v);
      4'd12:   r = !f.z && (f.n == f.v);
      4'd13:   r = f.z || (f.n != f.v);
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cxu_arith.sv
module cxu_arith
  import cxu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input  cxu_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] value,
  output nzcv_t             nzcv_new
);

  localparam logic [DATA_W-1:0] NMASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic              sub_sel;
  logic              add_like;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum_w;
  logic              carry_w;
  logic              carry_n;
  logic [DATA_W-1:0] raw;
  logic              a_top;
  logic              b_top;
  logic              r_top;

  assign sub_sel  = (op == OP_SUB) || (op == OP_CMP);
  assign add_like = (op == OP_ADD) || sub_sel;
  assign b_eff    = sub_sel ? ~opb : opb;

  // One adder serves both widths; the narrow carry is recovered from it.
  assign sum_w   = {1'b0, opa} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub_sel};
  assign carry_w = sum_w[DATA_W];
  assign carry_n = carry_into(sum_w[NARROW_W], opa[NARROW_W], b_eff[NARROW_W]);

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_CMP: raw = sum_w[DATA_W-1:0];
      OP_AND, OP_TST:         raw = opa & opb;
      OP_ORR:                 raw = opa | opb;
      OP_EOR:                 raw = opa ^ opb;
      OP_MVN:                 raw = ~opb;
      default:                raw = '0;
    endcase
  end

  assign value = wide ? raw : (raw & NMASK);

  assign a_top = wide ? opa[DATA_W-1]   : opa[NARROW_W-1];
  assign b_top = wide ? b_eff[DATA_W-1] : b_eff[NARROW_W-1];
  assign r_top = wide ? raw[DATA_W-1]   : raw[NARROW_W-1];

  assign nzcv_new.n = r_top;
  assign nzcv_new.z = (value == '0);
  assign nzcv_new.c = add_like && (wide ? carry_w : carry_n);
  assign nzcv_new.v = add_like && ovf_of(a_top, b_top, r_top);

endmodule

// File: rtl/cxu_cond.sv
module cxu_cond
  import cxu_pkg::*;
(
  input  logic [3:0] cond,
  input  nzcv_t      flags_q,
  output logic       hold
);

  assign hold = cond_holds(cond, flags_q);

endmodule

// File: rtl/cxu_resolve.sv
module cxu_resolve
  import cxu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  cxu_op_e           op,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic              hold,
  output logic [DATA_W-1:0] sel_val,
  output logic              zero_hit,
  output logic              taken
);

  localparam logic [DATA_W-1:0] NMASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] inc_b;
  logic [DATA_W-1:0] pick;
  logic              bit_one;

  assign inc_b = opb + {{(DATA_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (hold)                pick = opa;
    else if (op == OP_CSINC) pick = inc_b;
    else                     pick = opb;
  end

  assign sel_val  = wide ? pick : (pick & NMASK);
  assign zero_hit = wide ? (opa == '0) : ((opa & NMASK) == '0);
  assign bit_one  = opa[bit_sel];

  always_comb begin
    case (op)
      OP_CBZ:   taken = zero_hit;
      OP_CBNZ:  taken = !zero_hit;
      OP_TBZ:   taken = !bit_one;
      OP_TBNZ:  taken = bit_one;
      OP_BCOND: taken = hold;
      default:  taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/cxu_top.sv
module cxu_top
  import cxu_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32,
  localparam int SEL_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic              wide,
  input  logic              set_flags,
  input  logic [3:0]        cond,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [SEL_W-1:0]  bit_sel,
  output logic [DATA_W-1:0] result,
  output logic              res_we,
  output logic              taken,
  output logic [3:0]        flags
);

  cxu_op_e           op;
  nzcv_t             flags_q;
  nzcv_t             nzcv_new;
  logic [DATA_W-1:0] alu_val;
  logic [DATA_W-1:0] sel_val;
  logic              cond_hold;
  logic              zero_hit;
  logic              alu_visible;
  logic              is_select;
  logic              flag_we;

  assign op = cxu_op_e'(op_code);

  cxu_arith #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_arith (
    .op       (op),
    .wide     (wide),
    .opa      (opa),
    .opb      (opb),
    .value    (alu_val),
    .nzcv_new (nzcv_new)
  );

  cxu_cond u_cond (
    .cond    (cond),
    .flags_q (flags_q),
    .hold    (cond_hold)
  );

  cxu_resolve #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_resolve (
    .op       (op),
    .wide     (wide),
    .opa      (opa),
    .opb      (opb),
    .bit_sel  (bit_sel),
    .hold     (cond_hold),
    .sel_val  (sel_val),
    .zero_hit (zero_hit),
    .taken    (taken)
  );

  assign alu_visible = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
                       (op == OP_ORR) || (op == OP_EOR) || (op == OP_MVN);
  assign is_select   = (op == OP_CSEL) || (op == OP_CSINC);
  assign flag_we     = (op == OP_CMP) || (op == OP_TST) ||
                       (set_flags && alu_visible);

  always_ff @(posedge clk) begin
    if (!rst_n)       flags_q <= '0;
    else if (flag_we) flags_q <= nzcv_new;
  end

  always_comb begin
    if (alu_visible)    result = alu_val;
    else if (is_select) result = sel_val;
    else                result = '0;
  end

  assign res_we = alu_visible || is_select;
  assign flags  = flags_q;

endmodule

// File: rtl/cxu_checker.sv
module cxu_checker #(
  parameter int DATA_W   = 64,
  parameter int NARROW_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_code,
  input logic              wide,
  input logic              set_flags,
  input logic [3:0]        cond,
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] result,
  input logic              res_we,
  input logic              taken,
  input logic [3:0]        flags,
  input logic              cond_hold
);

  // R1: no update requested on an ALU op
  a_r1_hold_no_request: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_flags && op_code <= 4'd5) |=> $stable(flags));

  // R1: select, branch and nop never touch flags
  a_r1_hold_non_alu: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code >= 4'd8) |=> $stable(flags));

  // R2: stored Z matches the visible result of a flag-setting op
  a_r2_zero_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (set_flags && op_code <= 4'd5) |=> (flags[2] == ($past(result) == '0)));

  // R4: narrow results keep the upper half clear
  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !wide |-> (result[DATA_W-1:NARROW_W] == '0));

  // R5: compare and test discard their value
  a_r5_discard: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd6 || op_code == 4'd7) |-> (!res_we && result == '0));

  // R6, R11: equal condition follows stored Z
  a_r6_eq_follows_z: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd14 && cond == 4'd0) |-> (taken == flags[2]));

  // R6, R11: codes 14 and 15 always branch
  a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd14 && cond[3:1] == 3'b111) |-> taken);

  // R7: wide select with condition true passes A
  a_r7_select_a: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == 4'd8 && cond_hold && wide) |-> (result == opa));

  // R11: taken stays low outside branch opcodes
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code <= 4'd9 || op_code == 4'd15) |-> !taken);

endmodule

bind cxu_top cxu_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_code   (op_code),
  .wide      (wide),
  .set_flags (set_flags),
  .cond      (cond),
  .opa       (opa),
  .result    (result),
  .res_we    (res_we),
  .taken     (taken),
  .flags     (flags),
  .cond_hold (cond_hold)
);

// File: tb/cxu_top_test.sv
`timescale 1ns/1ps
module cxu_top_test;

  localparam logic [3:0] K_ADD = 4'd0, K_SUB = 4'd1, K_AND = 4'd2, K_ORR = 4'd3,
                         K_EOR = 4'd4, K_MVN = 4'd5, K_CMP = 4'd6, K_TST = 4'd7,
                         K_CSEL = 4'd8, K_CSINC = 4'd9, K_CBZ = 4'd10,
                         K_CBNZ = 4'd11, K_TBZ = 4'd12, K_TBNZ = 4'd13,
                         K_BCOND = 4'd14, K_NOP = 4'd15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  op_code;
  logic        wide;
  logic        set_flags;
  logic [3:0]  cond;
  logic [63:0] opa;
  logic [63:0] opb;
  logic [5:0]  bit_sel;
  logic [63:0] result;
  logic        res_we;
  logic        taken;
  logic [3:0]  flags;

  int   checks = 0;
  int   errors = 0;
  logic done   = 1'b0;
  logic [3:0] mflags = 4'b0000;

  always #2 clk = ~clk;

  cxu_top uut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .wide(wide),
    .set_flags(set_flags), .cond(cond), .opa(opa), .opb(opb),
    .bit_sel(bit_sel), .result(result), .res_we(res_we), .taken(taken),
    .flags(flags)
  );

  // ---------------- independent model ----------------
  function automatic logic [63:0] m_val(input logic [3:0] o, input logic w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] v;
    case (o)
      K_ADD:         v = a + b;
      K_SUB, K_CMP:  v = a - b;
      K_AND, K_TST:  v = a & b;
      K_ORR:         v = a | b;
      K_EOR:         v = a ^ b;
      K_MVN:         v = ~b;
      default:       v = 64'd0;
    endcase
    return w ? v : {32'd0, v[31:0]};
  endfunction

  function automatic logic [3:0] m_nzcv(input logic [3:0] o, input logic w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [63:0] v, ua, ub;
    logic signed [65:0] sa, sb, sr, hi, lo;
    logic [65:0] usum;
    logic n, z, c, ov;
    v  = m_val(o, w, a, b);
    n  = w ? v[63] : v[31];
    z  = (v == 64'd0);
    c  = 1'b0;
    ov = 1'b0;
    if (o == K_ADD || o == K_SUB || o == K_CMP) begin
      ua = w ? a : {32'd0, a[31:0]};
      ub = w ? b : {32'd0, b[31:0]};
      sa = w ? $signed({{2{a[63]}}, a}) : $signed({{34{a[31]}}, a[31:0]});
      sb = w ? $signed({{2{b[63]}}, b}) : $signed({{34{b[31]}}, b[31:0]});
      hi = w ? 66'sh0_7FFF_FFFF_FFFF_FFFF : 66'sh0_0000_0000_7FFF_FFFF;
      lo = -hi - 66'sd1;
      if (o == K_ADD) begin
        sr   = sa + sb;
        usum = {2'b00, ua} + {2'b00, ub};
        c    = w ? usum[64] : usum[32];
      end else begin
        sr = sa - sb;
        c  = (ua >= ub);
      end
      ov = (sr > hi) || (sr < lo);
    end
    return {n, z, c, ov};
  endfunction

  // condition built from pairs: odd codes invert, except 15
  function automatic logic m_cond(input logic [3:0] c, input logic [3:0] f);
    logic n, z, cy, v, base;
    {n, z, cy, v} = f;
    case (c[3:1])
      3'd0: base = z;
      3'd1: base = cy;
      3'd2: base = n;
      3'd3: base = v;
      3'd4: base = cy & ~z;
      3'd5: base = (n == v);
      3'd6: base = ~z & (n == v);
      default: base = 1'b1;
    endcase
    return (c[0] && c != 4'd15) ? ~base : base;
  endfunction

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic w, input logic sf,
                       input logic [3:0] c, input logic [63:0] a,
                       input logic [63:0] b, input logic [5:0] bs);
    @(negedge clk);
    op_code = o; wide = w; set_flags = sf; cond = c;
    opa = a; opb = b; bit_sel = bs;
    #1;
  endtask

  // Clock the currently driven op and check the stored flags afterward.
  task automatic commit(input string tag);
    if (op_code == K_CMP || op_code == K_TST || (set_flags && op_code <= K_MVN))
      mflags = m_nzcv(op_code, wide, opa, opb);
    @(posedge clk);
    #1;
    chk(tag, {60'd0, flags}, {60'd0, mflags});
  endtask

  task automatic set_by_cmp(input logic w, input logic [63:0] a, input logic [63:0] b);
    drive(K_CMP, w, 1'b0, 4'd0, a, b, 6'd0);
    commit("R1 cmp preset flags");
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    rst_n = 1'b0;
    drive(K_NOP, 1'b1, 1'b0, 4'd0, 64'd0, 64'd0, 6'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset flags zero", {60'd0, flags}, 64'd0);
    chk("R11 nop not taken", {63'd0, taken}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_add;
    drive(K_ADD, 1'b1, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    chk("R3 add wrap result", result, 64'd0);
    chk("R5 add writes", {63'd0, res_we}, 64'd1);
    commit("R3 add carry and zero flags");
    chk("R2 Z set on zero", {63'd0, flags[2]}, 64'd1);
    drive(K_ADD, 1'b1, 1'b0, 4'd0, 64'd5, 64'd7, 6'd0);
    chk("R3 add result", result, 64'd12);
    commit("R1 add without request holds flags");
    drive(K_ADD, 1'b1, 1'b1, 4'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 6'd0);
    commit("R3 add signed overflow");
    chk("R3 V on overflow", {63'd0, flags[0]}, 64'd1);
  endtask

  task automatic t_sub_narrow;
    drive(K_SUB, 1'b0, 1'b1, 4'd0, 64'hDEAD_BEEF_7FFF_FFFF, 64'h1234_5678_FFFF_FFFF, 6'd0);
    chk("R4 narrow sub result", result, 64'h0000_0000_8000_0000);
    commit("R4 narrow sub flags");
    chk("R4 narrow flags NV", {60'd0, flags}, 64'h9);
    drive(K_ADD, 1'b0, 1'b1, 4'd0, 64'h0000_0001_FFFF_FFFF, 64'd1, 6'd0);
    chk("R4 narrow add upper zero", result, 64'd0);
    commit("R4 narrow carry out of bit 31");
    drive(K_SUB, 1'b1, 1'b1, 4'd0, 64'd3, 64'd5, 6'd0);
    commit("R3 sub borrow clears C");
  endtask

  task automatic t_cmp_tst;
    drive(K_CMP, 1'b1, 1'b0, 4'd0, 64'd42, 64'd42, 6'd0);
    chk("R5 cmp result discarded", result, 64'd0);
    chk("R5 cmp no write", {63'd0, res_we}, 64'd0);
    commit("R5 cmp sets flags without request");
    drive(K_TST, 1'b1, 1'b0, 4'd0, 64'hF0, 64'h0F, 6'd0);
    chk("R5 tst no write", {63'd0, res_we}, 64'd0);
    commit("R3 tst clears C and V");
    drive(K_TST, 1'b0, 1'b0, 4'd0, 64'hFFFF_FFFF_8000_0000, 64'hFFFF_FFFF_8000_0000, 6'd0);
    commit("R4 tst narrow negative");
  endtask

  task automatic t_logic;
    drive(K_ORR, 1'b1, 1'b0, 4'd0, 64'hF0F0, 64'h0F00, 6'd0);
    chk("R3 orr", result, 64'hFFF0);
    drive(K_EOR, 1'b1, 1'b0, 4'd0, 64'hFF00_FF00_FF00_FF00, 64'hFFFF_0000_FFFF_0000, 6'd0);
    chk("R3 eor", result, 64'h00FF_FF00_00FF_FF00);
    drive(K_AND, 1'b1, 1'b0, 4'd0, 64'hFF00, 64'h0FF0, 6'd0);
    chk("R3 and", result, 64'h0F00);
    drive(K_MVN, 1'b0, 1'b1, 4'd0, 64'h1234, 64'hFFFF_FFFF_0000_0000, 6'd0);
    chk("R4 mvn narrow", result, 64'h0000_0000_FFFF_FFFF);
    commit("R2 mvn narrow sets N");
  endtask

  task automatic cond_sweep(input string tag);
    for (int c = 0; c < 16; c++) begin
      drive(K_BCOND, 1'b1, 1'b0, 4'(c), 64'd0, 64'd0, 6'd0);
      chk({"R6 R11 bcond ", tag}, {63'd0, taken}, {63'd0, m_cond(4'(c), mflags)});
    end
  endtask

  task automatic t_conds;
    set_by_cmp(1'b1, 64'd5, 64'd5);                       cond_sweep("equal");
    set_by_cmp(1'b1, 64'd3, 64'd5);                       cond_sweep("below");
    set_by_cmp(1'b1, 64'd5, 64'd3);                       cond_sweep("above");
    set_by_cmp(1'b1, 64'h8000_0000_0000_0000, 64'd1);     cond_sweep("ovf pos");
    set_by_cmp(1'b1, 64'd1, 64'h8000_0000_0000_0000);     cond_sweep("ovf neg");
  endtask

  task automatic t_select;
    set_by_cmp(1'b1, 64'd7, 64'd7);
    drive(K_CSEL, 1'b1, 1'b0, 4'd0, 64'd11, 64'd22, 6'd0);
    chk("R7 csel true", result, 64'd11);
    drive(K_CSEL, 1'b1, 1'b0, 4'd1, 64'd11, 64'd22, 6'd0);
    chk("R7 csel false", result, 64'd22);
    drive(K_CSINC, 1'b1, 1'b0, 4'd1, 64'd11, 64'd22, 6'd0);
    chk("R8 csinc false", result, 64'd23);
    drive(K_CSINC, 1'b1, 1'b0, 4'd0, 64'd11, 64'd22, 6'd0);
    chk("R8 csinc true", result, 64'd11);
    drive(K_CSINC, 1'b1, 1'b0, 4'd1, 64'd9, 64'd9, 6'd0);
    chk("R8 conditional increment", result, 64'd10);
    drive(K_CSINC, 1'b0, 1'b0, 4'd1, 64'd9, 64'h0000_0001_FFFF_FFFF, 6'd0);
    chk("R8 narrow increment wraps", result, 64'd0);
    drive(K_CSINC, 1'b1, 1'b0, 4'd1, 64'd9, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0);
    chk("R8 wide increment wraps", result, 64'd0);
    chk("R11 select not taken", {63'd0, taken}, 64'd0);
    drive(K_CSEL, 1'b1, 1'b1, 4'd0, 64'd0, 64'd0, 6'd0);
    commit("R1 select ignores set_flags");
  endtask

  task automatic t_branch;
    drive(K_CBZ, 1'b0, 1'b0, 4'd0, 64'hABCD_0000_0000_0000, 64'd0, 6'd0);
    chk("R9 cbz narrow low zero", {63'd0, taken}, 64'd1);
    drive(K_CBZ, 1'b1, 1'b0, 4'd0, 64'hABCD_0000_0000_0000, 64'd0, 6'd0);
    chk("R9 cbz wide nonzero", {63'd0, taken}, 64'd0);
    drive(K_CBNZ, 1'b1, 1'b0, 4'd0, 64'hABCD_0000_0000_0000, 64'd0, 6'd0);
    chk("R9 cbnz wide", {63'd0, taken}, 64'd1);
    drive(K_CBNZ, 1'b1, 1'b0, 4'd0, 64'd0, 64'd0, 6'd0);
    chk("R9 cbnz zero", {63'd0, taken}, 64'd0);
    drive(K_TBZ, 1'b1, 1'b0, 4'd0, 64'h8000_0000_0000_0000, 64'd0, 6'd63);
    chk("R10 tbz bit63 set", {63'd0, taken}, 64'd0);
    drive(K_TBNZ, 1'b1, 1'b0, 4'd0, 64'h8000_0000_0000_0000, 64'd0, 6'd63);
    chk("R10 tbnz bit63 set", {63'd0, taken}, 64'd1);
    drive(K_TBZ, 1'b1, 1'b0, 4'd0, 64'h8000_0000_0000_0000, 64'd0, 6'd0);
    chk("R10 tbz bit0 clear", {63'd0, taken}, 64'd1);
    chk("R5 branch no write", {63'd0, res_we}, 64'd0);
    drive(K_TBNZ, 1'b1, 1'b1, 4'd0, 64'd0, 64'd0, 6'd0);
    commit("R1 branch ignores set_flags");
    drive(K_ADD, 1'b1, 1'b0, 4'd0, 64'd0, 64'd0, 6'd0);
    chk("R11 add not taken", {63'd0, taken}, 64'd0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_add();
    t_sub_narrow();
    t_cmp_tst();
    t_logic();
    t_conds();
    t_select();
    t_branch();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule